// File: doc/BRIEF.md
# Link Integrity Test Monitor

This block decides whether the twisted-pair link of a 10 Mb/s receiver is alive. The receive front end hands it single-cycle strobes: one for each qualified link beat and one for each valid receive data event. A free-running millisecond tick sets its time base. From these it keeps one bit of state, link good or link failed. While the link is failed it withholds the transmit, receive, loopback and collision-detect enables from the rest of the port. It also reports the state on a status bit and on an active-low LED drive.

After reset the monitor assumes the link is down. It recovers on the first valid data, or on a run of six link beats whose spacing stays inside a window. In the good state, silence for a programmable number of ticks drops the link. Setting the disable control forces the good state for peers that send no link beats. The request to emit our own link beats depends only on transmit idleness, so beats keep going out while the link is failed.

Top module: `link_integrity_mon`

## Requirements
- R1: In the good state with the disable control low, the TIMEOUT_TICKS-th consecutive tick with no link pulse and no valid data moves the block to failed on that clock edge. Failed reads `link_fail`=1.
- R2: Any link pulse or valid data strobe while good restarts the silence count from zero. A tick in the same cycle as activity is not counted.
- R3: While failed, a valid data strobe returns the block to good on that clock edge.
- R4: While failed, a link pulse is consecutive if at most WINDOW_TICKS ticks have passed since the previous pulse. The PASS_PULSES-th (default 6) consecutive pulse returns the block to good. A gap of more than WINDOW_TICKS ticks restarts the run, and the next pulse counts as the first.
- R5: `tx_en`, `rx_en`, `loopback_en` and `coll_en` are 0 while failed and 1 while good.
- R6: `link_fail` is 1 while failed and 0 while good. `link_led_n` is 0 while good and 1 while failed.
- R7: While `dis_link_test` is 1 the block is in the good state from the next edge on, and no amount of silence fails it.
- R8: Asynchronous `rst_n` low, or synchronous `sw_rst` high, puts the block in the failed state and clears the pulse run and silence count. `link_chg` stays 0 for the reset.
- R9: `beat_req` equals the inverse of `tx_active` in both states.
- R10: `link_chg` is high for exactly the one cycle in which `link_fail` first shows a new value that was not caused by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset |
| ms_tick | input | 1 | One-cycle millisecond time base strobe |
| link_pulse | input | 1 | One-cycle qualified link beat strobe |
| rx_data_valid | input | 1 | One-cycle valid receive data strobe |
| dis_link_test | input | 1 | Forces the good state when high |
| tx_active | input | 1 | Transmitter is sending a frame |
| link_fail | output | 1 | Link failed status |
| link_led_n | output | 1 | Active-low link-good LED drive |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| loopback_en | output | 1 | Loopback enable |
| coll_en | output | 1 | Collision-detect enable |
| beat_req | output | 1 | Request to send outgoing link beats |
| link_chg | output | 1 | One-cycle link state change pulse |

## Verification
A silence counter that is off by one shows up as a link drop one tick early or late. That is visible on `link_fail` in the cycle after the deciding tick, so the bench counts ticks exactly around TIMEOUT_TICKS. A pulse-run counter or gap timer with the wrong state shows as recovery on the fifth pulse, or no recovery on the sixth. A gap of exactly WINDOW_TICKS ticks versus one tick more tells whether the window logic clears at the right time. Each such mistake appears at the ports within one clock of the pulse that exposes it. Random traffic is compared every cycle against a reference model built on unbounded counters.

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int TIMEOUT_TICKS = 100,
  parameter int WINDOW_TICKS  = 25,
  parameter int PASS_PULSES   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic ms_tick,
  input  logic link_pulse,
  input  logic rx_data_valid,
  input  logic dis_link_test,
  input  logic tx_active,
  output logic link_fail,
  output logic link_led_n,
  output logic tx_en,
  output logic rx_en,
  output logic loopback_en,
  output logic coll_en,
  output logic beat_req,
  output logic link_chg
);
  localparam int SW = $clog2(TIMEOUT_TICKS + 1);
  localparam int GW = $clog2(WINDOW_TICKS + 1);
  localparam int PW = $clog2(PASS_PULSES + 1);
  localparam logic [SW-1:0] SIL_LAST = SW'(TIMEOUT_TICKS - 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(WINDOW_TICKS);
  localparam logic [PW-1:0] RUN_LAST = PW'(PASS_PULSES - 1);

  logic [SW-1:0] sil_cnt;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] run_cnt;
  logic activity, timeout_hit, run_done, gap_expire, fail_nx;

  assign activity    = link_pulse | rx_data_valid;
  assign timeout_hit = !link_fail && !dis_link_test && !activity && ms_tick && (sil_cnt == SIL_LAST);
  assign run_done    = link_fail && link_pulse && (run_cnt == RUN_LAST);
  assign gap_expire  = !link_pulse && ms_tick && (gap_cnt == GAP_MAX);

  always_comb begin
    if (dis_link_test)  fail_nx = 1'b0;
    else if (link_fail) fail_nx = !(rx_data_valid || run_done);
    else                fail_nx = timeout_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_fail <= 1'b1;
      link_chg  <= 1'b0;
      sil_cnt   <= '0;
      gap_cnt   <= '0;
      run_cnt   <= '0;
    end else if (sw_rst) begin
      link_fail <= 1'b1;
      link_chg  <= 1'b0;
      sil_cnt   <= '0;
      gap_cnt   <= '0;
      run_cnt   <= '0;
    end else begin
      link_fail <= fail_nx;
      link_chg  <= fail_nx ^ link_fail;

      if (link_fail || dis_link_test || activity || timeout_hit) sil_cnt <= '0;
      else if (ms_tick)                                          sil_cnt <= sil_cnt + 1'b1;

      if (link_pulse)                         gap_cnt <= '0;
      else if (ms_tick && gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;

      if (!link_fail || !fail_nx) run_cnt <= '0;
      else if (link_pulse)        run_cnt <= run_cnt + 1'b1;
      else if (gap_expire)        run_cnt <= '0;
    end
  end

  assign link_led_n  = link_fail;
  assign tx_en       = !link_fail;
  assign rx_en       = !link_fail;
  assign loopback_en = !link_fail;
  assign coll_en     = !link_fail;
  assign beat_req    = !tx_active;

  p_silence_drop_r1: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (!link_fail && !dis_link_test && ms_tick && !activity && sil_cnt == SIL_LAST) |=> link_fail);

  p_drop_cause_r1: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    ($rose(link_fail) && !$past(sw_rst)) |-> ($past(ms_tick) && !$past(dis_link_test) && !$past(activity)));

  p_activity_clears_r2: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (!link_fail && activity) |=> (sil_cnt == '0));

  p_data_recover_r3: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (link_fail && rx_data_valid) |=> !link_fail);

  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    run_cnt < PW'(PASS_PULSES));

  p_forced_pass_r7: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    dis_link_test |=> !link_fail);

  p_chg_means_flip_r10: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    link_chg |-> (link_fail != $past(link_fail)));

  p_flip_means_chg_r10: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    ((link_fail != $past(link_fail)) && !$past(sw_rst)) |-> link_chg);
endmodule

// File: tb/link_integrity_mon_test.sv
module link_integrity_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 12;
  localparam int W = 3;
  localparam int P = 6;

  logic clk = 0, rst_n = 0, sw_rst = 0, ms_tick = 0, link_pulse = 0, rx_data_valid = 0;
  logic dis_link_test = 0, tx_active = 0;
  logic link_fail, link_led_n, tx_en, rx_en, loopback_en, coll_en, beat_req, link_chg;
  int checks = 0, errors = 0;
  bit done = 0;

  link_integrity_mon #(.TIMEOUT_TICKS(T), .WINDOW_TICKS(W), .PASS_PULSES(P)) uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ms_tick(ms_tick), .link_pulse(link_pulse),
    .rx_data_valid(rx_data_valid), .dis_link_test(dis_link_test), .tx_active(tx_active),
    .link_fail(link_fail), .link_led_n(link_led_n), .tx_en(tx_en), .rx_en(rx_en),
    .loopback_en(loopback_en), .coll_en(coll_en), .beat_req(beat_req), .link_chg(link_chg));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model on unbounded counters
  bit m_fail = 1, m_chg = 0;
  int quiet = 0, since = 0, run = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || sw_rst) begin
      m_fail = 1; m_chg = 0; quiet = 0; since = 0; run = 0;
    end else begin
      bit nf;
      nf = m_fail;
      if (link_pulse) begin
        run = (since <= W) ? run + 1 : 1;
        since = 0;
      end else if (ms_tick) since++;
      if (dis_link_test) nf = 0;
      else if (m_fail) begin
        if (rx_data_valid || run >= P) nf = 0;
      end else if (link_pulse || rx_data_valid) quiet = 0;
      else if (ms_tick) begin
        quiet++;
        if (quiet >= T) nf = 1;
      end
      if (!m_fail || !nf) run = 0;
      if (nf || dis_link_test) quiet = 0;
      m_chg = (nf != m_fail);
      m_fail = nf;
    end
  end

  function automatic logic [7:0] expected_vec();
    return {m_fail, m_fail, !m_fail, !m_fail, !m_fail, !m_fail, !tx_active, m_chg};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model(string req);
    chk(req, {link_fail, link_led_n, tx_en, rx_en, loopback_en, coll_en, beat_req, link_chg}, expected_vec());
  endtask

  // starts and ends at a falling edge
  task automatic drive(bit lp, bit dv, bit tk);
    link_pulse = lp; rx_data_valid = dv; ms_tick = tk;
    @(posedge clk);
    @(negedge clk);
    link_pulse = 0; rx_data_valid = 0; ms_tick = 0;
    compare_model("R5 R6 R9 R10 model");
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 1);
  endtask

  task automatic pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      drive(1, 0, 0);
      if (i != n - 1) ticks(gap);
    end
  endtask

  task automatic go_pass();
    drive(0, 1, 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R8 reset state", {link_fail, link_led_n, tx_en, link_chg}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    chk("R8 after release", {link_fail, link_chg}, 2'b10);

    go_pass();
    chk("R3 data recovers", {link_fail, link_chg, tx_en, rx_en}, 4'b0111);
    chk("R6 led on", {link_led_n}, 1'b0);
    drive(0, 0, 0);
    chk("R10 single cycle", {link_chg}, 1'b0);

    ticks(T - 1);
    chk("R1 one tick short", {link_fail}, 1'b0);
    ticks(1);
    chk("R1 timeout", {link_fail, link_chg, coll_en, loopback_en}, 4'b1100);

    go_pass();
    ticks(T - 4);
    drive(1, 0, 1);
    ticks(T - 1);
    chk("R2 pulse restarts", {link_fail}, 1'b0);
    drive(0, 1, 0);
    ticks(T - 1);
    chk("R2 data restarts", {link_fail}, 1'b0);
    ticks(1);
    chk("R2 fail after restart", {link_fail}, 1'b1);

    pulses(P - 1, W);
    chk("R4 five pulses not enough", {link_fail}, 1'b1);
    drive(0, 0, 0);
    drive(1, 0, 0);
    chk("R4 sixth pulse recovers", {link_fail, link_chg}, 2'b01);

    ticks(T);
    chk("R4 back to fail", {link_fail}, 1'b1);
    pulses(3, 1);
    ticks(W + 1);
    pulses(P - 1, 2);
    chk("R4 gap restarts run", {link_fail}, 1'b1);
    ticks(1);
    drive(1, 0, 0);
    chk("R4 run completes after gap", {link_fail}, 1'b0);

    ticks(T);
    dis_link_test = 1;
    drive(0, 0, 0);
    chk("R7 forced pass", {link_fail, tx_en}, 2'b01);
    ticks(3 * T);
    chk("R7 no timeout while disabled", {link_fail}, 1'b0);
    dis_link_test = 0;
    ticks(T);
    chk("R7 timeout after enable", {link_fail}, 1'b1);

    tx_active = 1;
    drive(0, 0, 0);
    chk("R9 busy in fail", {beat_req}, 1'b0);
    tx_active = 0;
    drive(0, 0, 0);
    chk("R9 idle in fail", {beat_req}, 1'b1);
    go_pass();
    tx_active = 1;
    drive(0, 0, 0);
    chk("R9 busy in pass", {beat_req}, 1'b0);
    tx_active = 0;

    sw_rst = 1;
    drive(0, 0, 0);
    sw_rst = 0;
    chk("R8 soft reset", {link_fail, link_chg, rx_en}, 3'b100);
    pulses(P - 1, 1);
    chk("R8 run cleared", {link_fail}, 1'b1);

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      int mode;
      mode = (i / 500) % 4;
      dis_link_test = ($urandom % 100) < 2;
      sw_rst = ($urandom % 1000) < 3;
      tx_active = $urandom % 2;
      case (mode)
        0: drive(($urandom % 4) == 0, ($urandom % 60) == 0, ($urandom % 2) == 0);
        1: drive(($urandom % 20) == 0, 1'b0, 1'b1);
        2: drive(($urandom % 3) == 0, 1'b0, ($urandom % 3) == 0);
        default: drive(($urandom % 8) == 0, ($urandom % 200) == 0, 1'b1);
      endcase
    end
    sw_rst = 0;
    dis_link_test = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule